// File: doc/BRIEF.md
# System Reset Source Controller

This block collects every request that can restart the system into one synchronous reset output. The requests are an active-low reset pin, end-of-count pulses from two watchdogs, a software request, a firewall violation, a wake-up from Standby, a register write that starts option loading, and Standby or Stop entry strobes that an option bit turns into resets. The reset output stays high for a fixed number of cycles after the last request is seen. Any new request during that time starts the count again.

Each source has a sticky cause flag, so software can find out after restart which request caused it. A system reset leaves the flags as they are. Only the power-on reset input clears them, or software writing the remove-flags strobe. When an option bit is set, a low-power entry strobe does not cause a reset. It goes out on the matching mode-entry output instead.

Top module: `sysrst_ctrl`

## Requirements
- R1: `sw_rst_req`, `wwdg_eoc`, `iwdg_eoc`, `stby_exit` and `fw_violation` are each sampled at the rising clock edge. A sampled high asserts `sys_rst` after that same edge and sets the source's cause bit. The cause bits are: 0 pin, 1 software, 2 window watchdog, 3 independent watchdog, 4 low-power entry, 5 option loader, 6 Standby exit, 7 firewall.
- R2: The reset pin passes through a two-flop synchronizer. A low seen by the synchronizer at two or more consecutive edges asserts `sys_rst` and sets bit 0. A low seen at only one edge is ignored: there is no reset and the flags do not change.
- R3: If `stby_entry` is high while `stby_keep_opt` is 0, the block asserts `sys_rst` after that edge, sets bit 4 and holds `stby_enter_o` low. If `stby_keep_opt` is 1, `stby_enter_o` follows `stby_entry` combinationally and there is no reset.
- R4: The Stop path works the same way, using `stop_entry`, `stop_keep_opt` and `stop_enter_o`.
- R5: A write with `ctl_wr_en` high and `ctl_wr_data` bit 18 set causes a reset and sets bit 5. A write with bit 18 clear does nothing. Bit 18 set while `ctl_wr_en` is low also does nothing.
- R6: `sys_rst` stays high for exactly 16 cycles after the last edge at which any request was sampled. A request during that window reloads the count.
- R7: After the pin returns high, `sys_rst` stays high for 18 cycles, counted from the first edge that samples the pin high. This is 2 cycles of synchronizer and filter plus the 16-cycle stretch.
- R8: The cause flags keep their value through and after `sys_rst`. `por_rst` clears every flag and holds `sys_rst` high. The output then stretches 16 cycles after the last edge at which `por_rst` is sampled high.
- R9: A `flag_clr` pulse clears every flag. A source sampled at the same edge as the clear keeps its bit. Sources sampled together all set their bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| ext_rst_n | input | 1 | Asynchronous reset pin, active low |
| wwdg_eoc | input | 1 | Window watchdog end-of-count pulse |
| iwdg_eoc | input | 1 | Independent watchdog end-of-count pulse |
| sw_rst_req | input | 1 | Software reset request |
| stby_entry | input | 1 | Standby entry sequence completed |
| stby_keep_opt | input | 1 | Option bit: 1 enters Standby, 0 resets |
| stop_entry | input | 1 | Stop entry sequence completed |
| stop_keep_opt | input | 1 | Option bit: 1 enters Stop, 0 resets |
| ctl_wr_en | input | 1 | Memory-control register write strobe |
| ctl_wr_data | input | 32 | Write data; bit 18 launches option loading |
| stby_exit | input | 1 | Wake-up from Standby |
| fw_violation | input | 1 | Firewall violation |
| flag_clr | input | 1 | Remove-flags strobe |
| sys_rst | output | 1 | Stretched system reset, active high |
| stby_enter_o | output | 1 | Standby entry passed to power control |
| stop_enter_o | output | 1 | Stop entry passed to power control |
| cause_flags | output | 8 | Sticky reset cause flags |

## Verification
The bench drives each pulse source alone, with low-power entry tried through both the Standby and the Stop path. It then drives every pair of sources. For each case it checks the exact flag pattern and the exact 16-cycle output width. A design that left out a source, put a flag in the wrong bit, or let one flag overwrite another would show the wrong pattern, and a counter off by one would show the wrong width. The bench also targets these corners:
- A one-cycle pin glitch, which an unfiltered design would turn into a reset.
- The 18-cycle release delay of the pin.
- A clear pulse that lands on the same edge as a new source; a design where clear wins would lose the new cause.
- A request during the stretch, which a counter that does not reload would cut short.
- Flags read after the reset ends, which a design that clears them with its own output would lose.
- Option writes with bit 18 clear, or with the write strobe low, which must not reset.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;

    localparam int NUM_SRC = 8;

    // Cause flag positions
    typedef enum logic [2:0] {
        SRC_PIN    = 3'd0,
        SRC_SOFT   = 3'd1,
        SRC_WWD    = 3'd2,
        SRC_IWD    = 3'd3,
        SRC_LOWPWR = 3'd4,
        SRC_OPTLD  = 3'd5,
        SRC_STBYX  = 3'd6,
        SRC_FWALL  = 3'd7
    } src_e;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    // One low-power entry path: strobe plus its keep option
    typedef struct packed {
        logic entry;
        logic keep;
    } lp_path_t;

    // Decoded outcome of a low-power entry path
    typedef struct packed {
        logic pass;
        logic reset;
    } lp_result_t;

    function automatic lp_result_t lp_decode(lp_path_t p);
        lp_result_t r;
        r.pass  = p.entry & p.keep;
        r.reset = p.entry & ~p.keep;
        return r;
    endfunction

    function automatic src_vec_t src_bit(src_e s, logic on);
        return on ? (src_vec_t'(1) << s) : '0;
    endfunction

endpackage

// File: rtl/sysrst_pin_filter.sv
module sysrst_pin_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYC    = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic active
);
    localparam int CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] FILT_MAX = CW'(FILT_CYC);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   pin_sync;
    logic [CW-1:0]          low_cnt;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= pin_n;
            end
        end
    endgenerate

    assign pin_sync = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst || pin_sync)       low_cnt <= '0;
        else if (low_cnt != FILT_MAX) low_cnt <= low_cnt + 1'b1;
    end

    assign active = (low_cnt == FILT_MAX);

endmodule

// File: rtl/sysrst_src_decode.sv
module sysrst_src_decode
    import sysrst_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int OPTLD_BIT = 18
) (
    input  logic              pin_act,
    input  logic              wwdg_eoc,
    input  logic              iwdg_eoc,
    input  logic              sw_rst_req,
    input  lp_path_t          stby,
    input  lp_path_t          stop,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              stby_exit,
    input  logic              fw_violation,
    output src_vec_t          req,
    output logic              stby_pass,
    output logic              stop_pass
);
    lp_result_t stby_res;
    lp_result_t stop_res;
    logic       opt_launch;
    logic       data_unused;

    assign stby_res    = lp_decode(stby);
    assign stop_res    = lp_decode(stop);
    assign opt_launch  = wr_en & wr_data[OPTLD_BIT];
    assign data_unused = ^wr_data;

    assign stby_pass = stby_res.pass;
    assign stop_pass = stop_res.pass;

    always_comb begin
        req = '0;
        req |= src_bit(SRC_PIN,    pin_act);
        req |= src_bit(SRC_SOFT,   sw_rst_req);
        req |= src_bit(SRC_WWD,    wwdg_eoc);
        req |= src_bit(SRC_IWD,    iwdg_eoc);
        req |= src_bit(SRC_LOWPWR, stby_res.reset | stop_res.reset);
        req |= src_bit(SRC_OPTLD,  opt_launch);
        req |= src_bit(SRC_STBYX,  stby_exit);
        req |= src_bit(SRC_FWALL,  fw_violation);
    end

endmodule

// File: rtl/sysrst_stretch.sv
module sysrst_stretch #(
    parameter int STRETCH_CYC = 16
) (
    input  logic clk,
    input  logic load,
    output logic rst_out
);
    localparam int CW = $clog2(STRETCH_CYC + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(STRETCH_CYC);

    logic [CW-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (load)                remain_q <= LOAD_VAL;
        else if (remain_q != '0) remain_q <= remain_q - 1'b1;
    end

    assign rst_out = (remain_q != '0);

endmodule

// File: rtl/sysrst_cause_reg.sv
module sysrst_cause_reg
    import sysrst_pkg::*;
(
    input  logic     clk,
    input  logic     por,
    input  logic     clr,
    input  src_vec_t req,
    output src_vec_t flags
);
    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
            always_ff @(posedge clk) begin
                if (por)         flags[i] <= 1'b0;
                else if (req[i]) flags[i] <= 1'b1;
                else if (clr)    flags[i] <= 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/sysrst_ctrl.sv
module sysrst_ctrl
    import sysrst_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int OPTLD_BIT   = 18,
    parameter int STRETCH_CYC = 16,
    parameter int FILT_CYC    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               por_rst,
    input  logic               ext_rst_n,
    input  logic               wwdg_eoc,
    input  logic               iwdg_eoc,
    input  logic               sw_rst_req,
    input  logic               stby_entry,
    input  logic               stby_keep_opt,
    input  logic               stop_entry,
    input  logic               stop_keep_opt,
    input  logic               ctl_wr_en,
    input  logic [DATA_W-1:0]  ctl_wr_data,
    input  logic               stby_exit,
    input  logic               fw_violation,
    input  logic               flag_clr,
    output logic               sys_rst,
    output logic               stby_enter_o,
    output logic               stop_enter_o,
    output logic [NUM_SRC-1:0] cause_flags
);
    logic     pin_act;
    src_vec_t req;
    lp_path_t stby_path;
    lp_path_t stop_path;

    assign stby_path = '{entry: stby_entry, keep: stby_keep_opt};
    assign stop_path = '{entry: stop_entry, keep: stop_keep_opt};

    sysrst_pin_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .FILT_CYC    (FILT_CYC)
    ) u_pin (
        .clk    (clk),
        .rst    (por_rst),
        .pin_n  (ext_rst_n),
        .active (pin_act)
    );

    sysrst_src_decode #(
        .DATA_W    (DATA_W),
        .OPTLD_BIT (OPTLD_BIT)
    ) u_dec (
        .pin_act      (pin_act),
        .wwdg_eoc     (wwdg_eoc),
        .iwdg_eoc     (iwdg_eoc),
        .sw_rst_req   (sw_rst_req),
        .stby         (stby_path),
        .stop         (stop_path),
        .wr_en        (ctl_wr_en),
        .wr_data      (ctl_wr_data),
        .stby_exit    (stby_exit),
        .fw_violation (fw_violation),
        .req          (req),
        .stby_pass    (stby_enter_o),
        .stop_pass    (stop_enter_o)
    );

    sysrst_stretch #(
        .STRETCH_CYC (STRETCH_CYC)
    ) u_stretch (
        .clk     (clk),
        .load    (por_rst | (|req)),
        .rst_out (sys_rst)
    );

    sysrst_cause_reg u_cause (
        .clk   (clk),
        .por   (por_rst),
        .clr   (flag_clr),
        .req   (req),
        .flags (cause_flags)
    );

endmodule

// File: rtl/sysrst_ctrl_chk.sv
module sysrst_ctrl_chk
    import sysrst_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int OPTLD_BIT   = 18,
    parameter int STRETCH_CYC = 16
) (
    input logic               clk,
    input logic               por_rst,
    input logic               ext_rst_n,
    input logic               wwdg_eoc,
    input logic               iwdg_eoc,
    input logic               sw_rst_req,
    input logic               stby_entry,
    input logic               stby_keep_opt,
    input logic               stop_entry,
    input logic               stop_keep_opt,
    input logic               ctl_wr_en,
    input logic [DATA_W-1:0]  ctl_wr_data,
    input logic               stby_exit,
    input logic               fw_violation,
    input logic               flag_clr,
    input logic               sys_rst,
    input logic               stby_enter_o,
    input logic               stop_enter_o,
    input logic [NUM_SRC-1:0] cause_flags
);
    localparam int HW = $clog2(STRETCH_CYC + 1) + 1;
    localparam logic [HW-1:0] HI_MAX = HW'(STRETCH_CYC);

    logic [HW-1:0] hi_cnt;
    logic          any_pulse;

    assign any_pulse = wwdg_eoc | iwdg_eoc | sw_rst_req | stby_entry | stop_entry
                     | (ctl_wr_en & ctl_wr_data[OPTLD_BIT]) | stby_exit | fw_violation;

    always_ff @(posedge clk) begin
        if (por_rst)             hi_cnt <= HI_MAX;
        else if (!sys_rst)       hi_cnt <= '0;
        else if (hi_cnt != HI_MAX) hi_cnt <= hi_cnt + 1'b1;
    end

    // R1
    wwd_flag_chk: assert property (@(posedge clk) disable iff (por_rst)
        wwdg_eoc |=> (sys_rst && cause_flags[SRC_WWD]));

    // R1
    fwall_flag_chk: assert property (@(posedge clk) disable iff (por_rst)
        fw_violation |=> (sys_rst && cause_flags[SRC_FWALL]));

    // R3
    stby_pass_chk: assert property (@(posedge clk) disable iff (por_rst)
        stby_enter_o |-> (stby_entry && stby_keep_opt));

    // R3
    stby_rst_chk: assert property (@(posedge clk) disable iff (por_rst)
        (stby_entry && !stby_keep_opt) |=> (sys_rst && cause_flags[SRC_LOWPWR]));

    // R4
    stop_pass_chk: assert property (@(posedge clk) disable iff (por_rst)
        stop_enter_o |-> (stop_entry && stop_keep_opt));

    // R4
    stop_rst_chk: assert property (@(posedge clk) disable iff (por_rst)
        (stop_entry && !stop_keep_opt) |=> (sys_rst && cause_flags[SRC_LOWPWR]));

    // R5
    optld_chk: assert property (@(posedge clk) disable iff (por_rst)
        (ctl_wr_en && ctl_wr_data[OPTLD_BIT]) |=> (sys_rst && cause_flags[SRC_OPTLD]));

    // R6
    stretch_len_chk: assert property (@(posedge clk) disable iff (por_rst)
        $fell(sys_rst) |-> (hi_cnt >= HI_MAX));

    // R8
    flag_keep_chk: assert property (@(posedge clk) disable iff (por_rst)
        !flag_clr |=> ((cause_flags & $past(cause_flags)) == $past(cause_flags)));

    // R8
    flag_rise_chk: assert property (@(posedge clk) disable iff (por_rst)
        ((cause_flags & ~$past(cause_flags)) != '0) |-> sys_rst);

    // R9
    clr_chk: assert property (@(posedge clk) disable iff (por_rst)
        (flag_clr && !any_pulse && ext_rst_n) |=> (cause_flags[NUM_SRC-1:1] == '0));

endmodule

bind sysrst_ctrl sysrst_ctrl_chk #(
    .DATA_W      (DATA_W),
    .OPTLD_BIT   (OPTLD_BIT),
    .STRETCH_CYC (STRETCH_CYC)
) u_chk (
    .clk           (clk),
    .por_rst       (por_rst),
    .ext_rst_n     (ext_rst_n),
    .wwdg_eoc      (wwdg_eoc),
    .iwdg_eoc      (iwdg_eoc),
    .sw_rst_req    (sw_rst_req),
    .stby_entry    (stby_entry),
    .stby_keep_opt (stby_keep_opt),
    .stop_entry    (stop_entry),
    .stop_keep_opt (stop_keep_opt),
    .ctl_wr_en     (ctl_wr_en),
    .ctl_wr_data   (ctl_wr_data),
    .stby_exit     (stby_exit),
    .fw_violation  (fw_violation),
    .flag_clr      (flag_clr),
    .sys_rst       (sys_rst),
    .stby_enter_o  (stby_enter_o),
    .stop_enter_o  (stop_enter_o),
    .cause_flags   (cause_flags)
);

// File: tb/sysrst_ctrl_test.sv
module sysrst_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int STRETCH    = 16;
    localparam int OPT_BIT    = 18;

    logic        clk = 1'b0;
    logic        por_rst = 1'b1;
    logic        ext_rst_n = 1'b1;
    logic        wwdg_eoc = 1'b0, iwdg_eoc = 1'b0, sw_rst_req = 1'b0;
    logic        stby_entry = 1'b0, stby_keep_opt = 1'b1;
    logic        stop_entry = 1'b0, stop_keep_opt = 1'b1;
    logic        ctl_wr_en = 1'b0;
    logic [31:0] ctl_wr_data = '0;
    logic        stby_exit = 1'b0, fw_violation = 1'b0, flag_clr = 1'b0;
    logic        sys_rst, stby_enter_o, stop_enter_o;
    logic [7:0]  cause_flags;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysrst_ctrl uut (
        .clk(clk), .por_rst(por_rst), .ext_rst_n(ext_rst_n),
        .wwdg_eoc(wwdg_eoc), .iwdg_eoc(iwdg_eoc), .sw_rst_req(sw_rst_req),
        .stby_entry(stby_entry), .stby_keep_opt(stby_keep_opt),
        .stop_entry(stop_entry), .stop_keep_opt(stop_keep_opt),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
        .stby_exit(stby_exit), .fw_violation(fw_violation), .flag_clr(flag_clr),
        .sys_rst(sys_rst), .stby_enter_o(stby_enter_o), .stop_enter_o(stop_enter_o),
        .cause_flags(cause_flags)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wwdg_eoc = 0; iwdg_eoc = 0; sw_rst_req = 0;
        stby_entry = 0; stop_entry = 0; stby_keep_opt = 1; stop_keep_opt = 1;
        ctl_wr_en = 0; ctl_wr_data = '0; stby_exit = 0; fw_violation = 0; flag_clr = 0;
    endtask

    // Bit positions: 1 soft, 2 window, 3 indep, 4 low-power, 5 option, 6 stby exit, 7 firewall
    task automatic drive_src(input logic [7:0] m, input bit via_stop);
        sw_rst_req    = m[1];
        wwdg_eoc      = m[2];
        iwdg_eoc      = m[3];
        stby_entry    = m[4] & ~via_stop;
        stop_entry    = m[4] & via_stop;
        stby_keep_opt = ~m[4];
        stop_keep_opt = ~m[4];
        ctl_wr_en     = m[5];
        ctl_wr_data   = m[5] ? (32'd1 << OPT_BIT) : 32'd0;
        stby_exit     = m[6];
        fw_violation  = m[7];
    endtask

    // Sits just after an edge; counts edges while sys_rst stays high
    task automatic measure(output int n);
        n = 0;
        while (sys_rst && n < 200) begin
            n++;
            @(posedge clk); #1;
        end
    endtask

    task automatic wait_quiet();
        int guard = 0;
        @(negedge clk);
        while (sys_rst && guard < 200) begin
            guard++;
            @(negedge clk);
        end
    endtask

    task automatic clear_flags(input string tag);
        @(negedge clk);
        flag_clr = 1;
        @(posedge clk); #1;
        flag_clr = 0;
        chk(tag, "flags after clear", int'(cause_flags), 0);
    endtask

    function automatic string tag_for(input int b);
        case (b)
            4: return "R3R4";
            5: return "R5";
            default: return "R1";
        endcase
    endfunction

    task automatic run_case(input logic [7:0] m, input bit via_stop, input string tag);
        int n;
        wait_quiet();
        drive_src(m, via_stop);
        @(posedge clk); #1;
        chk(tag, "sys_rst after source", int'(sys_rst), 1);
        chk(tag, "cause flags", int'(cause_flags), int'(m));
        chk(tag, "stby_enter_o", int'(stby_enter_o), 0);
        chk(tag, "stop_enter_o", int'(stop_enter_o), 0);
        idle_inputs();
        measure(n);
        chk("R6", "stretch length", n, STRETCH);
        chk("R8", "flags kept after reset", int'(cause_flags), int'(m));
        clear_flags("R9");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL R6 watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        idle_inputs();
        repeat (3) @(posedge clk);
        #1;
        // R8: power-on state
        chk("R8", "sys_rst during por", int'(sys_rst), 1);
        chk("R8", "flags during por", int'(cause_flags), 0);
        @(negedge clk);
        por_rst = 0;
        wait_quiet();
        chk("R8", "sys_rst released", int'(sys_rst), 0);

        // R1 R3 R4 R5: each source alone
        for (int b = 1; b < 8; b++) begin
            run_case(8'(1 << b), 1'b0, tag_for(b));
            if (b == 4) run_case(8'(1 << b), 1'b1, "R4");
        end

        // R9: every pair of sources together
        for (int a = 1; a < 8; a++)
            for (int b = a + 1; b < 8; b++)
                run_case(8'((1 << a) | (1 << b)), 1'(a & 1), "R9");

        // R3 / R4: keep option set passes entry through, no reset
        wait_quiet();
        stby_entry = 1; stby_keep_opt = 1;
        #1;
        chk("R3", "stby_enter_o pass", int'(stby_enter_o), 1);
        @(posedge clk); #1;
        chk("R3", "no reset on kept standby", int'(sys_rst), 0);
        stby_entry = 0;
        stop_entry = 1; stop_keep_opt = 1;
        #1;
        chk("R4", "stop_enter_o pass", int'(stop_enter_o), 1);
        chk("R3", "stby_enter_o idle", int'(stby_enter_o), 0);
        @(posedge clk); #1;
        chk("R4", "no reset on kept stop", int'(sys_rst), 0);
        chk("R4", "flags unchanged", int'(cause_flags), 0);
        idle_inputs();

        // R5: write without launch bit, launch bit without strobe
        @(negedge clk);
        ctl_wr_en = 1; ctl_wr_data = ~(32'd1 << OPT_BIT);
        @(posedge clk); #1;
        chk("R5", "write bit18 clear", int'(sys_rst), 0);
        @(negedge clk);
        ctl_wr_en = 0; ctl_wr_data = 32'd1 << OPT_BIT;
        @(posedge clk); #1;
        chk("R5", "no strobe", int'(sys_rst), 0);
        chk("R5", "flags unchanged", int'(cause_flags), 0);
        idle_inputs();

        // R2: one-cycle glitch ignored
        @(negedge clk); ext_rst_n = 0;
        @(negedge clk); ext_rst_n = 1;
        repeat (8) @(posedge clk);
        #1;
        chk("R2", "glitch no reset", int'(sys_rst), 0);
        chk("R2", "glitch no flag", int'(cause_flags), 0);

        // R2: two-cycle low accepted
        @(negedge clk); ext_rst_n = 0;
        repeat (2) @(negedge clk);
        ext_rst_n = 1;
        repeat (4) @(posedge clk);
        #1;
        chk("R2", "two-cycle low reset", int'(sys_rst), 1);
        chk("R2", "pin flag", int'(cause_flags), 1);
        wait_quiet();
        clear_flags("R9");

        // R7: release timing of a long low
        @(negedge clk); ext_rst_n = 0;
        repeat (6) @(negedge clk);
        ext_rst_n = 1;
        @(posedge clk); #1;
        measure(n);
        chk("R7", "pin release stretch", n, STRETCH + 2);
        chk("R7", "pin flag kept", int'(cause_flags), 1);

        // R9: clear colliding with a new source keeps the new one
        wait_quiet();
        sw_rst_req = 0; wwdg_eoc = 1; flag_clr = 1;
        @(posedge clk); #1;
        idle_inputs();
        chk("R9", "clear vs new source", int'(cause_flags), 4);

        // R6: a request inside the window reloads the count
        wait_quiet();
        iwdg_eoc = 1;
        @(posedge clk); #1;
        idle_inputs();
        repeat (4) @(posedge clk);
        @(negedge clk);
        fw_violation = 1;
        @(posedge clk); #1;
        idle_inputs();
        measure(n);
        chk("R6", "reload length", n, STRETCH);
        chk("R9", "accumulated flags", int'(cause_flags), 8'h8C);

        // R8: por clears flags and stretches
        @(negedge clk); por_rst = 1;
        @(posedge clk); #1;
        por_rst = 0;
        chk("R8", "por clears flags", int'(cause_flags), 0);
        measure(n);
        chk("R8", "por stretch", n, STRETCH);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule